// File: doc/BRIEF.md
# Parallel Configuration Bus Master

This block is the host side of a byte-wide parallel configuration port on a programmable target device. In load mode it takes configuration bytes from an upstream valid/ready stream. It then runs the whole sequence on the target pins: a program pulse, the wait for the target's init-ready flag, one clocked write per byte with optional stalling on the target's busy flag, and clock pulses after the last byte until the target reports configuration complete. Every wait has its own timeout. A timeout raises an abort pulse toward the target and ends the operation with a failure result.

In readback mode the block holds the data bus released, clocks a requested number of bytes out of the target and presents each one as a single-cycle valid pulse. Readback ends with chip-select released and one trailing clock pulse. A start strobe begins an operation, and the mode, byte count and stall enable are captured at that strobe. All pin changes happen on a step strobe that fires once every `STEP_DIV` clocks. A timeout fires once a wait has lasted more than `TIMEOUT_CYC` cycles.

Top module: `pcm_master`

## Requirements
- R1: Out of reset and while idle: program, chip-select and write-enable are low, the configuration clock is high, the data output-enable is low, and busy, done, timeout, abort and readback-valid are all low.
- R2: A load starts with program high while chip-select and write-enable are low. Program then returns low. No clock rising edge with chip-select and write-enable high occurs while the init input is low.
- R3: If init stays low for more than `TIMEOUT_CYC` cycles after program is released, abort, timeout and done pulse together for one cycle and the block returns to idle without clocking any byte.
- R4: When chip-select rises in a load, write-enable, output-enable and the configuration clock are already high at the same time, before the first byte is clocked.
- R5: In a load, stream bytes are accepted only while chip-select, write-enable and output-enable are high. Each accepted byte is placed on the data bus, the clock goes low and then high, and the data is stable at that rising edge. Bytes reach the target in stream order.
- R6: With stalling enabled, if busy is high at the check step after a rising edge, the block issues another low-high clock pulse with the same byte. The number of write edges is the byte count plus the number of stalled edges.
- R7: With stalling disabled, the busy input has no effect: exactly one write edge is issued per byte.
- R8: A busy stall lasting more than `TIMEOUT_CYC` cycles ends the load with abort, timeout and done pulsing together.
- R9: After the last byte, chip-select falls while write-enable is still high. Write-enable falls afterwards. The clock then pulses with chip-select low until the done input is seen high, and the load then ends with done high and timeout low.
- R10: If the done input stays low for more than `TIMEOUT_CYC` cycles of post-load clocking, abort, timeout and done pulse together.
- R11: In readback, chip-select is high, write-enable is low and output-enable is low. For each byte the clock goes low and then high. The data input is sampled one step after the rising edge and delivered in order as a one-cycle readback-valid pulse with that byte.
- R12: After the last readback byte, chip-select falls and exactly one low-high clock pulse follows with chip-select low. Readback then ends with done high and timeout low.
- R13: A start strobe during an operation is ignored, including its mode and count. Busy stays high until the result cycle and falls in the same cycle that done pulses.
- R14: A byte count of zero clocks no bytes. In load it goes straight to the end sequence, and in readback it delivers no readback-valid pulse and only the trailing pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_rd_i | input | 1 | 1 = readback, 0 = load (captured at start) |
| stall_en_i | input | 1 | Enable busy stalling in load (captured at start) |
| byte_cnt_i | input | CNT_W | Number of bytes to transfer (captured at start) |
| s_valid_i | input | 1 | Load stream byte valid |
| s_data_i | input | 8 | Load stream byte |
| s_ready_o | output | 1 | Load stream ready |
| m_valid_o | output | 1 | Readback byte valid pulse |
| m_data_o | output | 8 | Readback byte |
| prog_o | output | 1 | Program pin, high = asserted |
| cs_o | output | 1 | Chip-select pin, high = asserted |
| wr_o | output | 1 | Write-enable pin, high = asserted |
| cclk_o | output | 1 | Configuration clock pin |
| d_o | output | 8 | Data bus out |
| d_oe_o | output | 1 | Data bus output enable |
| d_i | input | 8 | Data bus in |
| init_i | input | 1 | Target init-ready flag |
| busy_i | input | 1 | Target busy flag |
| done_i | input | 1 | Target configuration-complete flag |
| op_busy_o | output | 1 | Operation in progress |
| op_done_o | output | 1 | One-cycle result pulse |
| timeout_o | output | 1 | Pulses with op_done_o on failure |
| abort_o | output | 1 | Abort pulse toward the target |

## Verification
Loads are run with a fresh byte pattern each time, against a target model whose init delay, busy stall position and length, and done latency can be set. The write edges it counts show three cases apart: a block that re-clocks stalled bytes, one that skips them, and one that ignores the stall enable. Separate runs hold init, busy or done inactive forever, so each of the three timeouts is checked on its own, and zero-count runs in both modes check that the sequences end without data. Readback runs compare the delivered bytes with the bytes the model drives after each rising edge and count the trailing pulse. A load carries a stray start strobe in the opposite mode to show that it is ignored.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WINIT, S_FETCH, S_LO, S_HI, S_CHK, S_CSOFF,
    S_WROFF, S_DCHK, S_DHI, S_RLO, S_RHI, S_RSMP, S_RXLO, S_RXHI
  } pcm_state_e;

  typedef struct packed {
    logic prog;
    logic cs;
    logic wr;
    logic cclk;
    logic oe;
  } pcm_pins_t;

  localparam pcm_pins_t PINS_IDLE = '{prog: 1'b0, cs: 1'b0, wr: 1'b0, cclk: 1'b1, oe: 1'b0};

endpackage

// File: rtl/pcm_step_gen.sv
module pcm_step_gen #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pcm_timeout.sv
module pcm_timeout #(
  parameter int TIMEOUT_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run_i && (cnt_q != LIMIT);

  always_comb begin
    if (!run_i)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == LIMIT);
endmodule

// File: rtl/pcm_seq.sv
module pcm_seq
  import pcm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             tmo_i,
  input  logic             start_i,
  input  logic             mode_rd_i,
  input  logic             stall_en_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  input  logic [7:0]       d_i,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  output pcm_pins_t        pins_o,
  output logic [7:0]       d_o,
  output logic             m_valid_o,
  output logic [7:0]       m_data_o,
  output logic             op_busy_o,
  output logic             op_done_o,
  output logic             timeout_o,
  output logic             abort_o,
  output logic             tmr_run_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pcm_state_e       state_q, state_d;
  pcm_pins_t        pins_q, pins_d;
  logic [7:0]       dat_q, dat_d, mdat_q, mdat_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             sen_q, sen_d, stl_q, stl_d;
  logic             mval_q, mval_d, fin_q, fin_d, tmo_q, tmo_d;

  assign tmr_run_o = (state_q == S_WINIT) || (state_q == S_DCHK) || (state_q == S_DHI) ||
                     (stl_q && ((state_q == S_HI) || (state_q == S_CHK)));

  always_comb begin
    state_d = state_q;  pins_d = pins_q;  dat_d = dat_q;  mdat_d = mdat_q;
    rem_d   = rem_q;    sen_d  = sen_q;   stl_d = stl_q;
    mval_d  = 1'b0;     fin_d  = 1'b0;    tmo_d = 1'b0;
    s_ready_o = 1'b0;
    if (state_q == S_IDLE) begin
      if (start_i) begin
        rem_d = byte_cnt_i;
        sen_d = stall_en_i;
        if (mode_rd_i) begin
          state_d = S_RLO;  pins_d.cs = 1'b1;
        end else begin
          state_d = S_PROG; pins_d.prog = 1'b1; pins_d.oe = 1'b1; dat_d = '0;
        end
      end
    end else if (tick_i) begin
      case (state_q)
        S_PROG:  begin pins_d.prog = 1'b0; state_d = S_WINIT; end
        S_WINIT: if (init_i) begin
                   pins_d.cs = 1'b1; pins_d.wr = 1'b1; pins_d.cclk = 1'b1;
                   state_d = (rem_q == '0) ? S_CSOFF : S_FETCH;
                 end
        S_FETCH: begin
                   s_ready_o = 1'b1;
                   if (s_valid_i) begin dat_d = s_data_i; state_d = S_LO; end
                 end
        S_LO:    begin pins_d.cclk = 1'b0; state_d = S_HI; end
        S_HI:    begin pins_d.cclk = 1'b1; state_d = S_CHK; end
        S_CHK:   if (sen_q && busy_i) begin
                   stl_d = 1'b1; pins_d.cclk = 1'b0; state_d = S_HI;
                 end else begin
                   stl_d = 1'b0; rem_d = rem_q - 1'b1;
                   state_d = (rem_q == ONE) ? S_CSOFF : S_FETCH;
                 end
        S_CSOFF: begin pins_d.cs = 1'b0; state_d = S_WROFF; end
        S_WROFF: begin pins_d.wr = 1'b0; pins_d.oe = 1'b0; state_d = S_DCHK; end
        S_DCHK:  if (done_i) begin
                   state_d = S_IDLE; fin_d = 1'b1;
                 end else begin
                   pins_d.cclk = 1'b0; state_d = S_DHI;
                 end
        S_DHI:   begin pins_d.cclk = 1'b1; state_d = S_DCHK; end
        S_RLO:   if (rem_q == '0) begin
                   pins_d.cs = 1'b0; state_d = S_RXLO;
                 end else begin
                   pins_d.cclk = 1'b0; state_d = S_RHI;
                 end
        S_RHI:   begin pins_d.cclk = 1'b1; state_d = S_RSMP; end
        S_RSMP:  begin
                   mdat_d = d_i; mval_d = 1'b1; rem_d = rem_q - 1'b1; state_d = S_RLO;
                 end
        S_RXLO:  begin pins_d.cclk = 1'b0; state_d = S_RXHI; end
        S_RXHI:  begin pins_d.cclk = 1'b1; state_d = S_IDLE; fin_d = 1'b1; end
        default: state_d = S_IDLE;
      endcase
    end
    if (tmo_i) begin
      state_d = S_IDLE; pins_d = PINS_IDLE; stl_d = 1'b0;
      fin_d = 1'b1; tmo_d = 1'b1; s_ready_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; pins_q <= PINS_IDLE; dat_q <= '0; mdat_q <= '0;
      rem_q <= '0; sen_q <= 1'b0; stl_q <= 1'b0;
      mval_q <= 1'b0; fin_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      state_q <= state_d; pins_q <= pins_d; dat_q <= dat_d; mdat_q <= mdat_d;
      rem_q <= rem_d; sen_q <= sen_d; stl_q <= stl_d;
      mval_q <= mval_d; fin_q <= fin_d; tmo_q <= tmo_d;
    end
  end

  assign pins_o    = pins_q;
  assign d_o       = dat_q;
  assign m_valid_o = mval_q;
  assign m_data_o  = mdat_q;
  assign op_busy_o = (state_q != S_IDLE);
  assign op_done_o = fin_q;
  assign timeout_o = tmo_q;
  assign abort_o   = tmo_q;
endmodule

// File: rtl/pcm_master.sv
module pcm_master
  import pcm_pkg::*;
#(
  parameter int STEP_DIV    = 4,
  parameter int TIMEOUT_CYC = 2_500_000,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_rd_i,
  input  logic             stall_en_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             m_valid_o,
  output logic [7:0]       m_data_o,
  output logic             prog_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic             cclk_o,
  output logic [7:0]       d_o,
  output logic             d_oe_o,
  input  logic [7:0]       d_i,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             op_busy_o,
  output logic             op_done_o,
  output logic             timeout_o,
  output logic             abort_o
);
  logic [1:0] rs_q;
  logic       rst_core_n, tick, tmo, tmr_run;
  pcm_pins_t  pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  pcm_step_gen #(.STEP_DIV(STEP_DIV)) step_i (
    .clk(clk), .rst_n(rst_core_n), .run_i(op_busy_o), .tick_o(tick)
  );

  pcm_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_core_n), .run_i(tmr_run), .expired_o(tmo)
  );

  pcm_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_core_n), .tick_i(tick), .tmo_i(tmo),
    .start_i(start_i), .mode_rd_i(mode_rd_i), .stall_en_i(stall_en_i),
    .byte_cnt_i(byte_cnt_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_ready_o(s_ready_o), .d_i(d_i), .init_i(init_i), .busy_i(busy_i),
    .done_i(done_i), .pins_o(pins), .d_o(d_o), .m_valid_o(m_valid_o),
    .m_data_o(m_data_o), .op_busy_o(op_busy_o), .op_done_o(op_done_o),
    .timeout_o(timeout_o), .abort_o(abort_o), .tmr_run_o(tmr_run)
  );

  assign prog_o = pins.prog;
  assign cs_o   = pins.cs;
  assign wr_o   = pins.wr;
  assign cclk_o = pins.cclk;
  assign d_oe_o = pins.oe;
endmodule

// File: rtl/pcm_master_chk.sv
module pcm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready_o,
  input logic       m_valid_o,
  input logic       prog_o,
  input logic       cs_o,
  input logic       wr_o,
  input logic       cclk_o,
  input logic [7:0] d_o,
  input logic       d_oe_o,
  input logic       op_busy_o,
  input logic       op_done_o,
  input logic       timeout_o,
  input logic       abort_o
);
  // R2: program pulse never overlaps an active bus
  p_prog_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> (!cs_o && !wr_o));

  // R5: stream handshake only with the write bus fully set up
  p_ready_bus_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (cs_o && wr_o && d_oe_o));

  // R5: data stable across a write rising edge
  p_data_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o && wr_o && $rose(cclk_o)) |-> $stable(d_o));

  // R8: abort only comes with a failed result
  p_abort_is_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (timeout_o && op_done_o));

  // R9: write-enable never falls while chip-select is still high
  p_cs_before_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> !cs_o);

  // R11: readback never drives the bus
  p_rd_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o && !wr_o) |-> !d_oe_o);

  // R11: readback bytes appear only inside the readback window
  p_mval_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> (cs_o && !wr_o));

  // R13: busy ends exactly at the result cycle
  p_busy_to_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_busy_o) |-> op_done_o);
endmodule

bind pcm_master pcm_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_ready_o(s_ready_o), .m_valid_o(m_valid_o),
  .prog_o(prog_o), .cs_o(cs_o), .wr_o(wr_o), .cclk_o(cclk_o), .d_o(d_o),
  .d_oe_o(d_oe_o), .op_busy_o(op_busy_o), .op_done_o(op_done_o),
  .timeout_o(timeout_o), .abort_o(abort_o)
);

// File: tb/pcm_master_tb_top.sv
`timescale 1ns/1ps
module pcm_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, mode_rd_i = 1'b0, stall_en_i = 1'b0;
  logic [7:0] byte_cnt_i = '0;
  logic       s_valid_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic       s_ready_o, m_valid_o;
  logic [7:0] m_data_o, d_o;
  logic       prog_o, cs_o, wr_o, cclk_o, d_oe_o;
  logic [7:0] d_i = '0;
  logic       init_i = 1'b1, busy_i = 1'b0, done_i = 1'b0;
  logic       op_busy_o, op_done_o, timeout_o, abort_o;

  always #2 clk = ~clk;

  pcm_master #(.STEP_DIV(2), .TIMEOUT_CYC(100), .CNT_W(8)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit ended = 0, mon_on = 0, cur_rd = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rb_q[$];
  int load_edges, post_edges, cap_cnt, cap_idx, rb_idx, mval_cnt, done_pulses, init_bad;
  int init_delay = 10, stall_byte = -1, stall_left = 0, done_after = 2;
  bit busy_force = 0;
  logic [7:0] ld_seed = 8'h11;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] rb_pat(input int k);
    logic [7:0] v;
    v = 8'(k * 29 + 60);
    return v ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ld_pat(input int k);
    return 8'(k * 7) + ld_seed;
  endfunction

  // target model: init handshake
  initial forever begin
    @(posedge prog_o);
    init_i = 1'b0;
    @(negedge prog_o);
    if (init_delay >= 0) begin
      repeat (init_delay) @(posedge clk);
      #1 init_i = 1'b1;
    end
  end

  // target model and scoreboard monitor on every clock rising edge
  initial forever begin
    logic [7:0] e;
    @(posedge cclk_o);
    #1;
    if (cs_o && wr_o) begin
      load_edges++;
      if (!init_i) init_bad++;
      if (cap_idx == stall_byte && stall_left > 0) begin
        stall_left--;
        busy_i = 1'b1;
      end else begin
        busy_i = busy_force;
        cap_cnt++;
        cap_idx++;
        if (exp_q.size() == 0) chk_eq("R5 unexpected byte", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk_eq("R5 byte order", int'(d_o), int'(e));
        end
      end
    end else if (cs_o) begin
      d_i = rb_pat(rb_idx);
      rb_idx++;
    end else begin
      post_edges++;
      if (done_after >= 0 && post_edges >= done_after) done_i = 1'b1;
    end
  end

  // R4 / R11: bus state when chip-select rises
  initial forever begin
    @(posedge cs_o);
    #1;
    if (mon_on) begin
      if (cur_rd) chk_eq("R11 cs rise {wr,oe,clk}", int'({wr_o, d_oe_o, cclk_o}), 1);
      else        chk_eq("R4 cs rise {wr,oe,clk}", int'({wr_o, d_oe_o, cclk_o}), 7);
    end
  end

  // R9: chip-select released before write-enable
  initial forever begin
    @(negedge cs_o);
    #1;
    if (mon_on && !cur_rd && !abort_o) chk_eq("R9 wr high at cs fall", int'(wr_o), 1);
  end

  // readback scoreboard and result pulse counter
  always @(negedge clk) begin
    if (mon_on && m_valid_o) begin
      mval_cnt++;
      if (rb_q.size() == 0) chk_eq("R11 unexpected readback byte", 1, 0);
      else chk_eq("R11 readback byte", int'(m_data_o), int'(rb_q.pop_front()));
    end
    if (mon_on && op_done_o) done_pulses++;
  end

  task automatic run_op(input bit rd, input int n, input bit sen, input bit poke,
                        output bit to_s, output bit ab_s);
    int idx, cyc;
    bit fin;
    exp_q.delete(); rb_q.delete();
    load_edges = 0; post_edges = 0; cap_cnt = 0; cap_idx = 0; rb_idx = 0;
    mval_cnt = 0; done_pulses = 0; init_bad = 0;
    cur_rd = rd; busy_i = busy_force; done_i = 1'b0; s_valid_i = 1'b0;
    for (int k = 0; k < n; k++) if (rd) rb_q.push_back(rb_pat(k));
    @(negedge clk);
    mode_rd_i = rd; stall_en_i = sen; byte_cnt_i = 8'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; cyc = 0; fin = 0; to_s = 0; ab_s = 0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 12) begin mode_rd_i = !rd; byte_cnt_i = 8'd2; start_i = 1'b1; end
      if (poke && cyc == 13) start_i = 1'b0;
      if (op_done_o) begin
        fin = 1; to_s = timeout_o; ab_s = abort_o;
      end else if (cyc > 20000) begin
        fin = 1; chk_eq("watchdog: operation never ended", 0, 1);
      end else if (!rd) begin
        if (!s_valid_i && idx < n) begin
          s_data_i = ld_pat(idx); exp_q.push_back(s_data_i); s_valid_i = 1'b1;
        end
        if (s_valid_i && s_ready_o) begin
          @(posedge clk); #1;
          s_valid_i = 1'b0; idx++;
        end
      end
    end
    start_i = 1'b0; s_valid_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit to, ab;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset / idle state
    chk_eq("R1 {prog,cs,wr,clk,oe}", int'({prog_o, cs_o, wr_o, cclk_o, d_oe_o}), 2);
    chk_eq("R1 {busy,done,timeout,abort,mvalid}",
           int'({op_busy_o, op_done_o, timeout_o, abort_o, m_valid_o}), 0);
    mon_on = 1;

    // R2 R4 R5 R9: plain load of 4 bytes
    ld_seed = 8'h11;
    run_op(0, 4, 1, 0, to, ab);
    chk_eq("R5 bytes captured", cap_cnt, 4);
    chk_eq("R5 write edges", load_edges, 4);
    chk_eq("R2 edges while init low", init_bad, 0);
    chk_eq("R9 post-load edges", post_edges, 2);
    chk_eq("R9 timeout on success", int'(to), 0);
    chk_eq("R13 single result pulse", done_pulses, 1);
    chk_eq("R1 idle pins after load", int'({prog_o, cs_o, wr_o, cclk_o, d_oe_o}), 2);

    // R6: busy stall on byte 1 for 3 edges
    ld_seed = 8'h40; stall_byte = 1; stall_left = 3;
    run_op(0, 4, 1, 0, to, ab);
    chk_eq("R6 write edges with stall", load_edges, 7);
    chk_eq("R6 bytes captured", cap_cnt, 4);
    chk_eq("R6 no timeout", int'(to), 0);
    stall_byte = -1; stall_left = 0;

    // R7: stalling disabled, busy held high
    ld_seed = 8'h80; busy_force = 1;
    run_op(0, 3, 0, 0, to, ab);
    chk_eq("R7 write edges busy ignored", load_edges, 3);
    chk_eq("R7 bytes captured", cap_cnt, 3);
    busy_force = 0;

    // R8: busy stall never ends
    ld_seed = 8'h22; stall_byte = 0; stall_left = 100000;
    run_op(0, 2, 1, 0, to, ab);
    chk_eq("R8 {abort,timeout}", int'({ab, to}), 3);
    chk_eq("R8 bytes captured", cap_cnt, 0);
    stall_byte = -1; stall_left = 0;

    // R3: init never rises
    init_delay = -1; ld_seed = 8'h33;
    run_op(0, 2, 0, 0, to, ab);
    chk_eq("R3 {abort,timeout}", int'({ab, to}), 3);
    chk_eq("R3 write edges", load_edges, 0);
    chk_eq("R3 busy after abort", int'(op_busy_o), 0);
    init_delay = 10;

    // R9: done arrives after 5 post-load edges
    ld_seed = 8'h5C; done_after = 5;
    run_op(0, 3, 1, 0, to, ab);
    chk_eq("R9 post-load edges until done", post_edges, 5);
    chk_eq("R9 {abort,timeout}", int'({ab, to}), 0);

    // R10: done never arrives
    done_after = -1; ld_seed = 8'h66;
    run_op(0, 2, 1, 0, to, ab);
    chk_eq("R10 {abort,timeout}", int'({ab, to}), 3);
    chk_eq("R10 bytes captured before done wait", cap_cnt, 2);
    done_after = 2;

    // R11 R12: readback of 3 bytes
    run_op(1, 3, 0, 0, to, ab);
    chk_eq("R11 readback bytes delivered", mval_cnt, 3);
    chk_eq("R12 trailing edges", post_edges, 1);
    chk_eq("R12 timeout", int'(to), 0);

    // R13: stray start during a load
    ld_seed = 8'h90;
    run_op(0, 5, 1, 1, to, ab);
    chk_eq("R13 bytes captured", cap_cnt, 5);
    chk_eq("R13 result pulses", done_pulses, 1);
    chk_eq("R13 no readback from stray start", mval_cnt, 0);
    repeat (40) @(negedge clk);
    chk_eq("R13 stays idle", int'(op_busy_o), 0);

    // R14: zero-count load and readback
    run_op(0, 0, 1, 0, to, ab);
    chk_eq("R14 zero load write edges", load_edges, 0);
    chk_eq("R14 zero load post edges", post_edges, 2);
    chk_eq("R14 zero load result", done_pulses, 1);
    run_op(1, 0, 0, 0, to, ab);
    chk_eq("R14 zero readback bytes", mval_cnt, 0);
    chk_eq("R14 zero readback trailing edges", post_edges, 1);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk_eq("watchdog expired", 0, 1);
    finish_run();
  end
endmodule